// File: doc/BRIEF.md
# Cipher Accelerator Control and Status Register File

This block is the register file of a cipher accelerator. It sits on a plain 32-bit register bus with an address, a write strobe, write data and combinational read data, and it holds four registers. The interrupt status register collects hardware completion and error events. The interrupt enable register gates those events onto one interrupt line. The control register issues start and flush strobes to the engines. The configuration register steers engine selection, FIFO byte swapping, DMA address modes and the hash input source.

Status bits are set by event inputs and cleared by software writing ones, so a handler can write back the value it read. The control register takes a per-bit write mask in the upper half of the write word. A strobe bit reaches the engines only when its mask bit is also set. Every strobe is a single-cycle pulse and reads back as zero. The interrupt output is registered.

Top module: `cipher_ctl_regs`

## Requirements
- R1: After reset every register reads as zero, `irq` is low, `eng_pulse` is zero and `conf_out` is zero.
- R2: A 1 on `evt_set[i]` during a clock edge sets status bit i, which reads at byte offset 0x00 from that edge on. The event order is: bit0 block DMA done, bit1 block DMA error, bit2 hash DMA done, bit3 hash DMA error, bit4 hash done, bit5 public-key done. The error bits form mask 0x0A and the two DMA done bits form mask 0x05.
- R3: A write to offset 0x00 clears each status bit whose write-data bit is 1 and leaves the other bits unchanged. Writing back the value that was read therefore clears exactly the bits that were set.
- R4: When an event sets a status bit in the same cycle that a write clears it, the bit ends up set.
- R5: The interrupt enable register at offset 0x04 is read/write in bits 5:0 and uses the status bit layout. Its bits 31:6 read as zero.
- R6: `irq` is the registered OR of (status AND enable). It goes high one cycle after an enabled status bit is set or enabled. It goes low one cycle after the last enabled set bit is cleared or disabled.
- R7: A write to offset 0x08 produces a one-cycle pulse on `eng_pulse[n]` in the cycle after the write edge, if and only if write-data bit n and bit n+16 are both 1. The pulse order for n = 0..9 is: AES start, TDES start, block start, hash start, public-key start, block flush, hash flush, public-key flush, random start, random flush.
- R8: The control register at offset 0x08 always reads as zero.
- R9: The configuration register at offset 0x0C is read/write in bits 8:0 and drives `conf_out`. Bits 1:0 are the hash input select, bit2 selects DES (1) or AES (0), bits 5:3 are FIFO byte-swap enables and bits 8:6 are DMA address-mode bits (1 means incrementing). Bits 31:9 read as zero.
- R10: Reads from any other address, including addresses that are not word aligned, return zero. Writes to those addresses change no register and produce no pulse.
- R11: When `reg_wr` is low, no register changes and no pulse is produced, whatever the address and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_addr | input | 8 | Byte address of the register access |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Combinational read data for `reg_addr` |
| evt_set | input | 6 | Hardware event inputs that set the status bits |
| irq | output | 1 | Registered interrupt request |
| eng_pulse | output | 10 | Single-cycle start and flush strobes to the engines |
| conf_out | output | 9 | Configuration register contents |

## Verification
The interrupt gate is swept over all 64 enable values with every status bit set. This separates a correct AND-OR combine from one that ignores the enable or drops a bit. Each control bit is written with its mask bit, without it, and with only the mask, which separates the masked pulse from plain data bits or a swapped half-word. All 512 configuration values are written and read back. The status clears are tried with the error mask, with zero, with a same-cycle set, and at the exact cycle `irq` drops. These exercise the write-one-to-clear rule, the set-wins priority and the registered interrupt delay. Writes to unaligned and unmapped offsets, and accesses with the write strobe low, are each followed by readback of every register.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
   localparam int unsigned REG_DW = 32;
   localparam int unsigned CTL_HALF = 16;

   // byte offsets of the registers
   localparam logic [7:0] OFS_STAT = 8'h00;
   localparam logic [7:0] OFS_ENA  = 8'h04;
   localparam logic [7:0] OFS_CTRL = 8'h08;
   localparam logic [7:0] OFS_CONF = 8'h0C;

   // status / enable bit positions
   localparam int unsigned EV_BLK_DMA_DONE = 0;
   localparam int unsigned EV_BLK_DMA_ERR  = 1;
   localparam int unsigned EV_HSH_DMA_DONE = 2;
   localparam int unsigned EV_HSH_DMA_ERR  = 3;
   localparam int unsigned EV_HSH_DONE     = 4;
   localparam int unsigned EV_PK_DONE      = 5;
   localparam logic [5:0] EV_ERR_MASK  = 6'h0A;
   localparam logic [5:0] EV_DONE_MASK = 6'h05;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_ENA,
      SEL_CTRL,
      SEL_CONF
   } reg_sel_e;
endpackage

// File: rtl/ccr_status.sv
module ccr_status #(
   parameter int unsigned N_EVT          = 6,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [N_EVT-1:0] evt_set,
   input  logic             clr_wr,
   input  logic [N_EVT-1:0] clr_bits,
   input  logic             ena_wr,
   input  logic [N_EVT-1:0] ena_bits,
   output logic [N_EVT-1:0] status,
   output logic [N_EVT-1:0] enable,
   output logic             irq
);
   logic [N_EVT-1:0] st_q, en_q, clr_mask, pend;
   logic             irq_q;

   assign clr_mask = clr_wr ? clr_bits : '0;
   assign pend     = st_q & en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q <= '0;
         en_q <= '0;
      end else begin
         // a set in the same cycle as a clear keeps the bit
         st_q <= (st_q & ~clr_mask) | evt_set;
         if (ena_wr) en_q <= ena_bits;
      end
   end

   generate
      if (IRQ_REGISTERED) begin : g_irq_reg
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) irq_q <= 1'b0;
            else        irq_q <= |pend;
         end
      end else begin : g_irq_comb
         assign irq_q = |pend;
      end
   endgenerate

   assign status = st_q;
   assign enable = en_q;
   assign irq    = irq_q;

   // R2 / R4: every event bit is set one edge later, even under a clear
   a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
      (evt_set != '0) |=> ((st_q & $past(evt_set)) == $past(evt_set)));

   // R3: a cleared bit with no coincident event reads zero afterwards
   a_r3_clear_takes: assert property (@(posedge clk) disable iff (!rst_n)
      clr_wr |=> ((st_q & $past(clr_bits & ~evt_set)) == '0));

   // R6: with nothing pending the line is low on the next cycle
   a_r6_irq_fall: assert property (@(posedge clk) disable iff (!rst_n)
      (IRQ_REGISTERED && pend == '0) |=> !irq);
endmodule

// File: rtl/ccr_ctrl.sv
module ccr_ctrl #(
   parameter int unsigned N_CTL = 10,
   parameter int unsigned HALF  = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [2*HALF-1:0] wdata,
   output logic [N_CTL-1:0]  pulse
);
   logic [N_CTL-1:0] req, msk, pulse_q;

   // lower half carries the values, upper half the per-bit write enables
   assign req = wdata[N_CTL-1:0];
   assign msk = wdata[HALF +: N_CTL];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pulse_q <= '0;
      else        pulse_q <= wr ? (req & msk) : '0;
   end

   assign pulse = pulse_q;

   // R7 / R11: no write, no strobe
   a_r7_no_write_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> (pulse == '0));

   // R7: only masked bits may strobe
   a_r7_mask_gates: assert property (@(posedge clk) disable iff (!rst_n)
      wr |=> ((pulse & ~$past(msk)) == '0));

   // R7: strobes never last two cycles
   a_r7_single_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      (pulse != '0) |=> ((pulse & $past(pulse)) == '0));
endmodule

// File: rtl/ccr_conf.sv
module ccr_conf #(
   parameter int unsigned CONF_W = 9
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [CONF_W-1:0] wdata,
   output logic [CONF_W-1:0] conf
);
   logic [CONF_W-1:0] conf_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  conf_q <= '0;
      else if (wr) conf_q <= wdata;
   end

   assign conf = conf_q;

   // R9 / R11: the value holds while not written
   a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |=> $stable(conf_q));
endmodule

// File: rtl/cipher_ctl_regs.sv
module cipher_ctl_regs
   import ccr_pkg::*;
#(
   parameter int unsigned AW             = 8,
   parameter int unsigned N_EVT          = 6,
   parameter int unsigned N_CTL          = 10,
   parameter int unsigned CONF_W         = 9,
   parameter bit          IRQ_REGISTERED = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [AW-1:0]     reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   input  logic [N_EVT-1:0]  evt_set,
   output logic              irq,
   output logic [N_CTL-1:0]  eng_pulse,
   output logic [CONF_W-1:0] conf_out
);
   localparam int unsigned EVT_PAD  = REG_DW - N_EVT;
   localparam int unsigned CONF_PAD = REG_DW - CONF_W;

   // elaboration-time parameter checks
   generate
      if (AW < 4 || AW > 16) begin : g_bad_aw
         $error("AW must be between 4 and 16");
      end
      if (N_EVT < 1 || N_EVT >= REG_DW) begin : g_bad_evt
         $error("N_EVT must be in 1..31");
      end
      if (N_CTL < 1 || N_CTL > CTL_HALF) begin : g_bad_ctl
         $error("N_CTL must be in 1..16");
      end
      if (CONF_W < 1 || CONF_W >= REG_DW) begin : g_bad_conf
         $error("CONF_W must be in 1..31");
      end
   endgenerate

   reg_sel_e         sel;
   logic [N_EVT-1:0] status, enable;
   logic             wr_stat, wr_ena, wr_ctrl, wr_conf;

   always_comb begin
      sel = SEL_NONE;
      if      (reg_addr == AW'(OFS_STAT)) sel = SEL_STAT;
      else if (reg_addr == AW'(OFS_ENA))  sel = SEL_ENA;
      else if (reg_addr == AW'(OFS_CTRL)) sel = SEL_CTRL;
      else if (reg_addr == AW'(OFS_CONF)) sel = SEL_CONF;
   end

   assign wr_stat = reg_wr && (sel == SEL_STAT);
   assign wr_ena  = reg_wr && (sel == SEL_ENA);
   assign wr_ctrl = reg_wr && (sel == SEL_CTRL);
   assign wr_conf = reg_wr && (sel == SEL_CONF);

   ccr_status #(.N_EVT(N_EVT), .IRQ_REGISTERED(IRQ_REGISTERED)) u_status (
      .clk      (clk),
      .rst_n    (rst_n),
      .evt_set  (evt_set),
      .clr_wr   (wr_stat),
      .clr_bits (reg_wdata[N_EVT-1:0]),
      .ena_wr   (wr_ena),
      .ena_bits (reg_wdata[N_EVT-1:0]),
      .status   (status),
      .enable   (enable),
      .irq      (irq)
   );

   ccr_ctrl #(.N_CTL(N_CTL), .HALF(CTL_HALF)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_ctrl),
      .wdata (reg_wdata),
      .pulse (eng_pulse)
   );

   ccr_conf #(.CONF_W(CONF_W)) u_conf (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (wr_conf),
      .wdata (reg_wdata[CONF_W-1:0]),
      .conf  (conf_out)
   );

   // read mux; control strobes always read back as zero
   always_comb begin
      unique case (sel)
         SEL_STAT: reg_rdata = {{EVT_PAD{1'b0}}, status};
         SEL_ENA:  reg_rdata = {{EVT_PAD{1'b0}}, enable};
         SEL_CONF: reg_rdata = {{CONF_PAD{1'b0}}, conf_out};
         default:  reg_rdata = '0;
      endcase
   end

   // R10: unmapped offsets never touch a register
   a_r10_unmapped_no_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && sel == SEL_NONE) |=> (eng_pulse == '0));

   // R8: control address reads zero
   a_r8_ctrl_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == SEL_CTRL) |-> (reg_rdata == '0));

   // R5: enable changes only on its own write
   a_r5_enable_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_ena |=> $stable(enable));
endmodule

// File: tb/sim_cipher_ctl_regs.sv
`timescale 1ns/1ps
module sim_cipher_ctl_regs;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic [5:0]  evt_set = '0;
   logic        irq;
   logic [9:0]  eng_pulse;
   logic [8:0]  conf_out;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cipher_ctl_regs u0 (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .evt_set(evt_set),
      .irq(irq), .eng_pulse(eng_pulse), .conf_out(conf_out)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; reg_wdata = '0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wr = 1'b0;
      #1 d = reg_rdata;
   endtask

   task automatic evt(input logic [5:0] v);
      @(negedge clk);
      evt_set = v;
      @(negedge clk);
      evt_set = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset values
      rd(8'h00, d); chk("R1 status", d, 0);
      rd(8'h04, d); chk("R1 enable", d, 0);
      rd(8'h08, d); chk("R1 ctrl", d, 0);
      rd(8'h0C, d); chk("R1 conf", d, 0);
      chk("R1 irq", {31'b0, irq}, 0);
      chk("R1 pulse", {22'b0, eng_pulse}, 0);
      chk("R1 conf_out", {23'b0, conf_out}, 0);

      // R5 enable width
      wr(8'h04, 32'hFFFF_FFFF);
      rd(8'h04, d); chk("R5 enable upper zero", d, 32'h3F);
      wr(8'h04, 32'h0);

      // R2 each event bit alone
      for (int i = 0; i < 6; i++) begin
         evt(6'(1 << i));
         rd(8'h00, d); chk("R2 single event", d, 32'(1 << i));
         chk("R6 disabled no irq", {31'b0, irq}, 0);
         wr(8'h00, 32'(1 << i));
         rd(8'h00, d); chk("R3 single clear", d, 0);
      end

      // R6 sweep over all enable values with every status bit set
      evt(6'h3F);
      for (int e = 0; e < 64; e++) begin
         wr(8'h04, 32'(e));
         @(negedge clk);
         chk("R6 irq vs enable", {31'b0, irq}, {31'b0, (e != 0)});
         rd(8'h04, d); chk("R5 enable readback", d, 32'(e));
      end

      // R3 clear with the error mask, with zero, then the done mask
      wr(8'h00, 32'h0A);
      rd(8'h00, d); chk("R3 clear errors", d, 32'h35);
      wr(8'h00, 32'h00);
      rd(8'h00, d); chk("R3 zero write keeps", d, 32'h35);
      wr(8'h00, 32'h05);
      rd(8'h00, d); chk("R3 clear dma done", d, 32'h30);
      wr(8'h00, 32'h30);
      rd(8'h00, d); chk("R3 write back read value", d, 0);

      // R4 set wins over a same-cycle clear
      evt(6'h01);
      @(negedge clk);
      reg_addr = 8'h00; reg_wdata = 32'h03; reg_wr = 1'b1; evt_set = 6'h02;
      @(negedge clk);
      reg_wr = 1'b0; evt_set = '0; reg_wdata = '0;
      rd(8'h00, d); chk("R4 set wins", d, 32'h02);
      wr(8'h00, 32'h3F);

      // R6 exact rise and fall timing
      wr(8'h04, 32'h04);
      @(negedge clk);
      evt_set = 6'h04;
      @(negedge clk);
      evt_set = '0;
      chk("R6 irq not yet high", {31'b0, irq}, 0);
      @(negedge clk);
      chk("R6 irq high one cycle later", {31'b0, irq}, 1);
      wr(8'h00, 32'h04);
      chk("R6 irq still high at clear", {31'b0, irq}, 1);
      @(negedge clk);
      chk("R6 irq low one cycle after clear", {31'b0, irq}, 0);

      // R7 per-bit masked pulses
      for (int n = 0; n < 10; n++) begin
         wr(8'h08, 32'(1 << n) | 32'(1 << (n + 16)));
         chk("R7 masked pulse", {22'b0, eng_pulse}, 32'(1 << n));
         @(negedge clk);
         chk("R7 pulse one cycle", {22'b0, eng_pulse}, 0);
         wr(8'h08, 32'(1 << n));
         chk("R7 unmasked no pulse", {22'b0, eng_pulse}, 0);
         wr(8'h08, 32'(1 << (n + 16)));
         chk("R7 mask only no pulse", {22'b0, eng_pulse}, 0);
      end
      wr(8'h08, 32'h03FF_03FF);
      chk("R7 all strobes", {22'b0, eng_pulse}, 32'h3FF);
      wr(8'h08, 32'h00F0_0155);
      chk("R7 partial mask", {22'b0, eng_pulse}, 32'h050);

      // R8 control reads zero
      wr(8'h08, 32'hFFFF_FFFF);
      rd(8'h08, d); chk("R8 ctrl reads zero", d, 0);

      // R9 configuration sweep
      for (int v = 0; v < 512; v++) begin
         wr(8'h0C, 32'(v));
         chk("R9 conf_out", {23'b0, conf_out}, 32'(v));
         rd(8'h0C, d); chk("R9 conf readback", d, 32'(v));
      end
      wr(8'h0C, 32'hFFFF_FFFF);
      rd(8'h0C, d); chk("R9 conf upper zero", d, 32'h1FF);

      // R10 unmapped and unaligned addresses
      wr(8'h0C, 32'h0A5);
      wr(8'h04, 32'h11);
      evt(6'h22);
      for (int k = 0; k < 8; k++) begin
         logic [7:0] a;
         case (k)
            0: a = 8'h01; 1: a = 8'h02; 2: a = 8'h03; 3: a = 8'h09;
            4: a = 8'h0D; 5: a = 8'h10; 6: a = 8'h80; default: a = 8'hFC;
         endcase
         wr(a, 32'hFFFF_FFFF);
         chk("R10 no pulse", {22'b0, eng_pulse}, 0);
         rd(a, d); chk("R10 reads zero", d, 0);
      end
      rd(8'h00, d); chk("R10 status kept", d, 32'h22);
      rd(8'h04, d); chk("R10 enable kept", d, 32'h11);
      rd(8'h0C, d); chk("R10 conf kept", d, 32'h0A5);

      // R11 strobe low does nothing
      for (int k = 0; k < 4; k++) begin
         @(negedge clk);
         reg_addr = 8'(k * 4); reg_wdata = 32'hFFFF_FFFF; reg_wr = 1'b0;
         @(negedge clk);
         chk("R11 no pulse", {22'b0, eng_pulse}, 0);
      end
      reg_wdata = '0;
      rd(8'h00, d); chk("R11 status kept", d, 32'h22);
      rd(8'h04, d); chk("R11 enable kept", d, 32'h11);
      rd(8'h0C, d); chk("R11 conf kept", d, 32'h0A5);

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule